// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder for a Three-Phase Brushless Motor

This block converts the three Hall position sensor signals of a three-phase brushless DC motor into on/off commands for the six switches of the power bridge. Each phase has one high-side switch and one low-side switch. The sensor code first passes through a multi-flop synchroniser. It is then decoded into one of six commutation steps, and each step selects one high-side switch and one low-side switch of two different phases. The decode table depends on a two-bit select that describes the electrical spacing of the sensors. A direction input swaps the high and low roles of the two driven phases, so the motor runs in reverse.

The drive-enable input comes from an external PWM and overcurrent gate and qualifies every drive output. Any sensor code that is not part of the selected spacing's cycle blanks the bridge. The brake input overrides all other inputs: it turns every high-side switch off and every low-side switch on, which shorts the windings together. All six outputs are registered.

Top module: `hall_commutator`

## Requirements
- R1: `spacingSel` uses 00 for 60° and 01 for 120°. The hall code is written {hallIn[2],hallIn[1],hallIn[0]}. Steps 0..5 for 60° are the codes 000,001,011,111,110,100. Steps 0..5 for 120° are the codes 001,011,010,110,100,101.
- R2: `spacingSel` uses 10 for 240° and 11 for 300°. Steps 0..5 for 240° are the codes 001,101,100,110,010,011. Steps 0..5 for 300° are the codes 000,100,110,111,011,001.
- R3: Output bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. In forward direction (`dirFwd`=1) the steps drive (high-side phase, low-side phase) as follows: step 0 (A,B), step 1 (A,C), step 2 (B,C), step 3 (B,A), step 4 (C,A), step 5 (C,B).
- R4: With `dirFwd`=0, the same code turns on the opposite pairing. The high-side phase of the forward case becomes the low-side phase, and the low-side phase becomes the high-side phase.
- R5: A code outside the selected cycle turns all six outputs off. These codes are 010 and 101 for 60° and 300°, and 000 and 111 for 120° and 240°.
- R6: With `driveEnable` low and `brake` low, all six outputs are off.
- R7: With `brake` high, `hsOn` is 000 and `lsOn` is 111. This holds whatever the direction, enable, spacing or code.
- R8: A change on `hallIn` reaches the outputs at the third rising clock edge after it, and not earlier. Changes on `brake`, `driveEnable`, `dirFwd` and `spacingSel` reach the outputs at the next rising edge.
- R9: The high-side and low-side outputs of one phase are never on together. Outside braking, at most one high-side output and at most one low-side output are on, and the two counts are equal.
- R10: While `rstN` is low, all six outputs are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hallIn | input | 3 | Raw Hall sensor code, asynchronous to clk |
| spacingSel | input | 2 | Sensor spacing: 00=60°, 01=120°, 10=240°, 11=300° |
| dirFwd | input | 1 | 1 = forward, 0 = reverse |
| driveEnable | input | 1 | Drive qualifier from the PWM/overcurrent gate |
| brake | input | 1 | 1 = short the windings through the low side |
| hsOn | output | 3 | High-side switch commands, bit 0 = phase A |
| lsOn | output | 3 | Low-side switch commands, bit 0 = phase A |

## Verification
A new Hall code travels through two synchroniser flops and the output register, so its drive pattern is due at the third rising edge. The brake, enable, direction and spacing inputs skip the synchroniser and are due at the first rising edge. The table walk waits four edges after each vector before it samples, so it never looks at a half-settled result. Directed tests sample exactly at these edges: the old Hall pattern must still be present after two edges and the new one after three, and the brake pattern must appear after one. All inputs are driven and all outputs sampled on the falling clock edge.

// File: rtl/comm_pkg.sv
`timescale 1ns/1ps
package comm_pkg;
  localparam int PHASES  = 3;
  localparam int HALL_W  = 3;
  localparam int STEPS   = 6;
  localparam int STEP_W  = $clog2(STEPS);
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SPACE_60  = 2'b00,
    SPACE_120 = 2'b01,
    SPACE_240 = 2'b10,
    SPACE_300 = 2'b11
  } spacing_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              valid;
    logic [STEP_W-1:0] step;
    logic              fwd;
    logic              enable;
    logic              brake;
  } drive_strobe_t;
endpackage

// File: rtl/comm_ctrl.sv
`timescale 1ns/1ps
module comm_ctrl
  import comm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALL_W-1:0] hallIn,
  input  logic [SEL_W-1:0]  spacingSel,
  input  logic              dirFwd,
  input  logic              driveEnable,
  input  logic              brake,
  output drive_strobe_t     strobe
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [HALL_W-1:0] syncChain [SYNC_STAGES];
  logic [HALL_W-1:0] syncCode;
  logic              wideFamily;
  logic              reversedOrder;
  logic              matchValid;
  logic [STEP_W-1:0] matchIdx;
  logic [STEP_W-1:0] stepIdx;

  // Base cycle of one spacing family, by position in the cycle
  function automatic logic [HALL_W-1:0] baseCode(input logic wide, input int idx);
    logic [HALL_W-1:0] code;
    if (wide) begin
      case (idx)
        0: code = 3'b001;
        1: code = 3'b011;
        2: code = 3'b010;
        3: code = 3'b110;
        4: code = 3'b100;
        default: code = 3'b101;
      endcase
    end else begin
      case (idx)
        0: code = 3'b000;
        1: code = 3'b001;
        2: code = 3'b011;
        3: code = 3'b111;
        4: code = 3'b110;
        default: code = 3'b100;
      endcase
    end
    return code;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= hallIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncCode = syncChain[LAST_STAGE];

  always_comb begin
    wideFamily    = (spacing_e'(spacingSel) == SPACE_120) ||
                    (spacing_e'(spacingSel) == SPACE_240);
    reversedOrder = spacingSel[1];
    matchValid    = 1'b0;
    matchIdx      = '0;
    for (int i = 0; i < STEPS; i++) begin
      if (syncCode == baseCode(wideFamily, i)) begin
        matchValid = 1'b1;
        matchIdx   = STEP_W'(i);
      end
    end
    if (reversedOrder && (matchIdx != '0))
      stepIdx = STEP_W'(STEPS) - matchIdx;
    else
      stepIdx = matchIdx;
  end

  always_comb begin
    strobe.valid  = matchValid;
    strobe.step   = stepIdx;
    strobe.fwd    = dirFwd;
    strobe.enable = driveEnable;
    strobe.brake  = brake;
  end
endmodule

// File: rtl/comm_dp.sv
`timescale 1ns/1ps
module comm_dp
  import comm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  drive_strobe_t     strobe,
  output logic [PHASES-1:0] hsOn,
  output logic [PHASES-1:0] lsOn
);
  int                hiIdx;
  int                loIdx;
  int                srcIdx;
  int                sinkIdx;
  logic              live;
  logic [PHASES-1:0] hsNext;
  logic [PHASES-1:0] lsNext;

  always_comb begin
    hiIdx = int'(strobe.step) / 2;
    loIdx = (int'(strobe.step) + 1) / 2 + 1;
    if (loIdx >= PHASES) loIdx = loIdx - PHASES;
    srcIdx  = strobe.fwd ? hiIdx : loIdx;
    sinkIdx = strobe.fwd ? loIdx : hiIdx;
    live    = strobe.valid && strobe.enable;
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign hsNext[p] = strobe.brake ? 1'b0 : (live && (srcIdx == p));
    assign lsNext[p] = strobe.brake ? 1'b1 : (live && (sinkIdx == p));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsOn <= '0;
      lsOn <= '0;
    end else begin
      hsOn <= hsNext;
      lsOn <= lsNext;
    end
  end
endmodule

// File: rtl/hall_commutator.sv
`timescale 1ns/1ps
module hall_commutator
  import comm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       hallIn,
  input  logic [1:0]       spacingSel,
  input  logic             dirFwd,
  input  logic             driveEnable,
  input  logic             brake,
  output logic [2:0]       hsOn,
  output logic [2:0]       lsOn
);
  drive_strobe_t strobe;

  comm_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hallIn     (hallIn),
    .spacingSel (spacingSel),
    .dirFwd     (dirFwd),
    .driveEnable(driveEnable),
    .brake      (brake),
    .strobe     (strobe)
  );

  comm_dp i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .hsOn  (hsOn),
    .lsOn  (lsOn)
  );
endmodule

// File: rtl/comm_checker.sv
`timescale 1ns/1ps
module comm_checker
  import comm_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          brake,
  input logic          driveEnable,
  input drive_strobe_t strobe,
  input logic [2:0]    hsOn,
  input logic [2:0]    lsOn
);
  AST_BRAKE_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    brake |=> (hsOn == 3'b000 && lsOn == 3'b111)); // R7

  AST_ENABLE_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (!driveEnable && !brake) |=> (hsOn == 3'b000 && lsOn == 3'b000)); // R6

  AST_INVALID_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.valid && !strobe.brake) |=> (hsOn == 3'b000 && lsOn == 3'b000)); // R5

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (hsOn & lsOn) == 3'b000); // R9

  AST_SINGLE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (lsOn != 3'b111) |-> ($countones(hsOn) == $countones(lsOn) && $onehot0(hsOn))); // R9
endmodule

bind hall_commutator comm_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .brake      (brake),
  .driveEnable(driveEnable),
  .strobe     (strobe),
  .hsOn       (hsOn),
  .lsOn       (lsOn)
);

// File: tb/test_hall_commutator.sv
`timescale 1ns/1ps
module test_hall_commutator;
  localparam real HALF_NS = 2.5;
  localparam int  WATCHDOG_CYCLES = 100000;

  // cycle codes per spacing select, step 0..5 (R1, R2)
  localparam logic [2:0] SEQ [4][6] = '{
    '{3'b000, 3'b001, 3'b011, 3'b111, 3'b110, 3'b100},
    '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101},
    '{3'b001, 3'b101, 3'b100, 3'b110, 3'b010, 3'b011},
    '{3'b000, 3'b100, 3'b110, 3'b111, 3'b011, 3'b001}
  };
  // forward pairing per step (R3)
  localparam int PAIR_HI [6] = '{0, 0, 1, 1, 2, 2};
  localparam int PAIR_LO [6] = '{1, 2, 2, 0, 0, 1};
  // out-of-cycle codes per spacing select (R5)
  localparam logic [2:0] BAD [4][2] = '{
    '{3'b010, 3'b101}, '{3'b000, 3'b111}, '{3'b000, 3'b111}, '{3'b010, 3'b101}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hallIn = 3'b001;
  logic [1:0] spacingSel = 2'b00;
  logic       dirFwd = 1'b1;
  logic       driveEnable = 1'b1;
  logic       brake = 1'b0;
  logic [2:0] hsOn;
  logic [2:0] lsOn;
  int checks = 0;
  int errors = 0;

  always #(HALF_NS) clk = ~clk;

  hall_commutator i_hall_commutator (
    .clk(clk), .rstN(rstN), .hallIn(hallIn), .spacingSel(spacingSel),
    .dirFwd(dirFwd), .driveEnable(driveEnable), .brake(brake),
    .hsOn(hsOn), .lsOn(lsOn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] expHs, input logic [2:0] expLs);
    checks++;
    if (hsOn !== expHs || lsOn !== expLs) begin
      errors++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", req, hsOn, lsOn, expHs, expLs);
    end
  endtask

  initial begin
    tick(3);
    check("R10 reset", 3'b000, 3'b000);
    rstN = 1'b1;
    tick(4);

    // table walk: every spacing, step and direction (R1 R2 R3 R4)
    for (int sel = 0; sel < 4; sel++) begin
      for (int st = 0; st < 6; st++) begin
        for (int d = 0; d < 2; d++) begin
          logic [2:0] eh;
          logic [2:0] el;
          spacingSel = 2'(sel);
          hallIn = SEQ[sel][st];
          dirFwd = (d == 0);
          tick(4);
          eh = 3'(1 << (d == 0 ? PAIR_HI[st] : PAIR_LO[st]));
          el = 3'(1 << (d == 0 ? PAIR_LO[st] : PAIR_HI[st]));
          check(sel < 2 ? (d == 0 ? "R1 R3 decode" : "R1 R4 reverse")
                        : (d == 0 ? "R2 R3 decode" : "R2 R4 reverse"), eh, el);
        end
      end
    end

    // invalid codes blank (R5)
    dirFwd = 1'b1;
    for (int sel = 0; sel < 4; sel++) begin
      for (int b = 0; b < 2; b++) begin
        spacingSel = 2'(sel);
        hallIn = BAD[sel][b];
        tick(4);
        check("R5 invalid code", 3'b000, 3'b000);
      end
    end

    // enable low blanks (R6)
    spacingSel = 2'b01;
    hallIn = 3'b010;
    tick(4);
    check("R3 pre-enable", 3'b010, 3'b100);
    driveEnable = 1'b0;
    tick(1);
    check("R6 enable low", 3'b000, 3'b000);
    driveEnable = 1'b1;
    tick(1);
    check("R8 enable restore one edge", 3'b010, 3'b100);

    // brake priority (R7)
    brake = 1'b1;
    tick(1);
    check("R7 brake one edge", 3'b000, 3'b111);
    driveEnable = 1'b0;
    tick(1);
    check("R7 brake over enable", 3'b000, 3'b111);
    hallIn = 3'b111;
    dirFwd = 1'b0;
    tick(4);
    check("R7 brake over invalid code", 3'b000, 3'b111);
    brake = 1'b0;
    tick(1);
    check("R5 after brake release", 3'b000, 3'b000);
    driveEnable = 1'b1;

    // hall latency: exactly three edges (R8)
    spacingSel = 2'b00;
    dirFwd = 1'b1;
    hallIn = 3'b000;
    tick(4);
    check("R8 settle step0", 3'b001, 3'b010);
    hallIn = 3'b001;
    tick(2);
    check("R8 not before third edge", 3'b001, 3'b010);
    tick(1);
    check("R8 at third edge", 3'b001, 3'b100);
    dirFwd = 1'b0;
    tick(1);
    check("R8 R4 direction one edge", 3'b100, 3'b001);

    // reset while driving (R10)
    rstN = 1'b0;
    tick(1);
    check("R10 reset mid-run", 3'b000, 3'b000);
    rstN = 1'b1;
    tick(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule